// File: doc/BRIEF.md
# Privilege Mode and Exception Router

This block keeps track of the execution mode of a processor core and decides what happens to that mode when exception requests arrive. There are three modes: user, supervisor and fault. A request taken in user mode suspends the user program and enters a supervisor handler. A request taken in supervisor mode is a double fault and enters fault mode. Requests that arrive together are resolved by a fixed priority, and the block reports the winner as a 3-bit cause code. The cause code is valid only during a one-cycle handler-entry pulse.

A debug event raised in supervisor mode is reported as its own cause, supervisor-debug. After its handler finishes in fault mode, control returns to supervisor mode. Any other double fault is terminal: the core stays in fault mode until reset. The mode that was interrupted is pushed on a small return stack when a handler is entered. A return strobe pops that stack, so nested handlers unwind in order: from fault to supervisor, then from supervisor to user.

Top module: `priv_exc_router`

## Requirements
- R1: After a synchronous active-low reset, the mode is user (code 0), the saved return mode is user, the entry pulse is low and the cause code is 0.
- R2: In user mode, any request moves the mode to supervisor (code 1) at the next clock edge. It raises the entry pulse for that one cycle and shows user as the saved return mode.
- R3: In supervisor mode, any request moves the mode to fault (code 2) at the next clock edge, with an entry pulse, and supervisor becomes the saved return mode.
- R4: In supervisor mode, a debug request that wins arbitration is reported as cause 5 (supervisor-debug). A later return strobe in fault mode goes back to supervisor, and the saved return mode becomes user again.
- R5: A double fault whose winning cause is not debug makes fault mode terminal. From then until reset, return strobes and requests change nothing and produce no pulse.
- R6: The winner of simultaneous requests follows this order, highest first: memory fault (cause 1), unknown instruction (2), SVC (3), debug (4), hardware management (6). The four synchronous causes therefore all rank above the asynchronous one.
- R7: In supervisor mode, a return strobe goes back to user mode with no entry pulse. In user mode, a return strobe is ignored.
- R8: The cause code is 0 in every cycle in which the entry pulse is low. The pulse never lasts more than one cycle for a single request.
- R9: Requests that arrive in a non-terminal fault mode are ignored: no pulse, and neither the mode nor the saved return mode changes.
- R10: When a request and a return strobe arrive in the same cycle, the request is taken and the return strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| memflt_req | input | 1 | Memory fault request (synchronous) |
| unkins_req | input | 1 | Unknown instruction request (synchronous) |
| svc_req | input | 1 | Supervisor call request (synchronous) |
| dbg_req | input | 1 | Breakpoint or watchpoint match (synchronous) |
| hwmg_req | input | 1 | Hardware management event (asynchronous) |
| ret_strobe | input | 1 | Handler return |
| mode_o | output | 2 | Current mode: 0 user, 1 supervisor, 2 fault |
| cause_o | output | 3 | Cause of the handler just entered, 0 when idle |
| enter_o | output | 1 | One-cycle handler-entry pulse |
| saved_mode_o | output | 2 | Mode that a return strobe would resume |

## Verification
The assertions check the single-step rules on every cycle:
- a request in user mode leads to supervisor mode, and a request in supervisor mode leads to fault mode;
- a terminal fault mode never leaves fault mode;
- the cause code is zero outside the entry pulse;
- a supervisor-debug entry always lands in fault mode;
- the return stack never overflows or underflows.

Only the bench scenarios can show the behaviours that span several cycles or depend on arbitration. These include the full nested unwind from fault back to supervisor and then to user, the exact priority order of simultaneous requests, and whether a dropped return strobe or an ignored fault-mode request leaves the saved mode untouched.

// File: rtl/priv_pkg.sv
// Shared encodings for the privilege mode and exception router.
// Assumes request index order is the arbitration order (index 0 highest).
package priv_pkg;
    typedef enum logic [1:0] {
        MODE_USER  = 2'd0,
        MODE_SUPER = 2'd1,
        MODE_FAULT = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_MEMFLT = 3'd1,
        CAUSE_UNKINS = 3'd2,
        CAUSE_SVC    = 3'd3,
        CAUSE_DEBUG  = 3'd4,
        CAUSE_SDEBUG = 3'd5,
        CAUSE_HWMG   = 3'd6
    } cause_e;

    localparam int NUM_REQ = 5;
    localparam int REQ_MEM = 0;
    localparam int REQ_UNK = 1;
    localparam int REQ_SVC = 2;
    localparam int REQ_DBG = 3;
    localparam int REQ_HW  = 4;

    // Map a request index to its cause code.
    function automatic cause_e idx2cause(input int idx);
        case (idx)
            REQ_MEM: return CAUSE_MEMFLT;
            REQ_UNK: return CAUSE_UNKINS;
            REQ_SVC: return CAUSE_SVC;
            REQ_DBG: return CAUSE_DEBUG;
            REQ_HW:  return CAUSE_HWMG;
            default: return CAUSE_NONE;
        endcase
    endfunction
endpackage

// File: rtl/priv_cause_sel.sv
// Fixed-priority selector over exception requests.
// The lowest set index wins. Purely combinational; the caller registers the result.
module priv_cause_sel
    import priv_pkg::*;
#(
    parameter int N = NUM_REQ
) (
    input  logic [N-1:0] req,
    output logic         hit,
    output cause_e       cause,
    output logic         is_dbg
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] sel;

    // Scan from the lowest priority upward so the highest-priority request is written last.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                sel = IW'(i);
            end
        end
    end

    // Translate the winning index into a cause code.
    always_comb begin
        cause  = hit ? idx2cause(int'(sel)) : CAUSE_NONE;
        is_dbg = hit && (int'(sel) == REQ_DBG);
    end

    // R6
    no_winner_chk: assert property (@(req) (req == '0) |-> !hit) else $error("R6 winner without request");
endmodule

// File: rtl/priv_ret_stack.sv
// Return-mode stack: pushes the interrupted mode on handler entry and pops it on return.
// Assumes the caller never pushes when full or pops when empty. Reads as user when empty.
module priv_ret_stack
    import priv_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  mode_e push_mode,
    input  logic  pop,
    output mode_e top_mode
);
    localparam int CW = $clog2(DEPTH + 1);

    mode_e         stk_q [DEPTH];
    logic [CW-1:0] cnt_q;

    // Track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (push && !pop)     cnt_q <= cnt_q + 1'b1;
        else if (pop && !push)     cnt_q <= cnt_q - 1'b1;
    end

    // Store the pushed mode in its slot.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)                                stk_q[g] <= MODE_USER;
                else if (push && !pop && cnt_q == CW'(g)) stk_q[g] <= push_mode;
            end
        end
    endgenerate

    // Present the newest entry.
    always_comb begin
        top_mode = MODE_USER;
        for (int i = 0; i < DEPTH; i++)
            if (cnt_q == CW'(i + 1)) top_mode = stk_q[i];
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q < CW'(DEPTH))) else $error("R3 stack overflow");
    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0)) else $error("R7 stack underflow");
endmodule

// File: rtl/priv_exc_router.sv
// Privilege mode tracker and exception router.
// Holds the current mode and takes requests: user escalates to supervisor, supervisor to fault.
// Records the interrupted mode and unwinds on return strobes.
// Assumes one return strobe per handler exit. Requests in fault mode are dropped.
module priv_exc_router
    import priv_pkg::*;
#(
    parameter int STACK_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       memflt_req,
    input  logic       unkins_req,
    input  logic       svc_req,
    input  logic       dbg_req,
    input  logic       hwmg_req,
    input  logic       ret_strobe,
    output logic [1:0] mode_o,
    output logic [2:0] cause_o,
    output logic       enter_o,
    output logic [1:0] saved_mode_o
);
    logic [NUM_REQ-1:0] req_vec;
    logic               hit, is_dbg, take, do_ret;
    cause_e             win_cause, cause_q;
    mode_e              mode_q, mode_d, top_mode;
    logic               term_q, enter_q;

    // Gather requests in priority order.
    always_comb begin
        req_vec          = '0;
        req_vec[REQ_MEM] = memflt_req;
        req_vec[REQ_UNK] = unkins_req;
        req_vec[REQ_SVC] = svc_req;
        req_vec[REQ_DBG] = dbg_req;
        req_vec[REQ_HW]  = hwmg_req;
    end

    priv_cause_sel #(.N(NUM_REQ)) u_sel (
        .req    (req_vec),
        .hit    (hit),
        .cause  (win_cause),
        .is_dbg (is_dbg)
    );

    // Decide between taking an exception, returning, or holding.
    always_comb begin
        take   = hit && (mode_q != MODE_FAULT);
        do_ret = ret_strobe && !take &&
                 ((mode_q == MODE_SUPER) || (mode_q == MODE_FAULT && !term_q));
        if (take)        mode_d = (mode_q == MODE_USER) ? MODE_SUPER : MODE_FAULT;
        else if (do_ret) mode_d = top_mode;
        else             mode_d = mode_q;
    end

    priv_ret_stack #(.DEPTH(STACK_DEPTH)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .push_mode (mode_q),
        .pop       (do_ret),
        .top_mode  (top_mode)
    );

    // Register the mode, the terminal flag and the entry pulse with its cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_USER;
            term_q  <= 1'b0;
            enter_q <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            mode_q  <= mode_d;
            enter_q <= take;
            if (take && mode_q == MODE_SUPER && !is_dbg) term_q <= 1'b1;
            if (!take)                                   cause_q <= CAUSE_NONE;
            else if (mode_q == MODE_SUPER && is_dbg)     cause_q <= CAUSE_SDEBUG;
            else                                         cause_q <= win_cause;
        end
    end

    assign mode_o       = mode_q;
    assign cause_o      = cause_q;
    assign enter_o      = enter_q;
    assign saved_mode_o = top_mode;

    // R2
    user_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_USER && hit) |=> (mode_o == MODE_SUPER && enter_o)) else $error("R2");
    // R3
    super_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SUPER && hit) |=> (mode_o == MODE_FAULT && enter_o)) else $error("R3");
    // R5
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_FAULT && term_q) |=> (mode_o == MODE_FAULT && !enter_o)) else $error("R5");
    // R8
    cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enter_o |-> (cause_o == CAUSE_NONE)) else $error("R8");
    // R4
    sdebug_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_o && cause_o == CAUSE_SDEBUG) |-> (mode_o == MODE_FAULT)) else $error("R4");
    // R7
    user_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_USER && !hit) |=> (mode_o == MODE_USER && !enter_o)) else $error("R7");
endmodule

// File: tb/tb_priv_exc_router.sv
module tb_priv_exc_router;
    logic clk = 1'b0, rst_n = 1'b0;
    logic memflt_req = 0, unkins_req = 0, svc_req = 0, dbg_req = 0, hwmg_req = 0, ret_strobe = 0;
    logic [1:0] mode_o, saved_mode_o;
    logic [2:0] cause_o;
    logic       enter_o;

    int errors = 0, checks = 0;
    int m_mode = 0;   // 0 user, 1 super, 2 fault
    bit m_term = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    priv_exc_router dut (
        .clk(clk), .rst_n(rst_n), .memflt_req(memflt_req), .unkins_req(unkins_req),
        .svc_req(svc_req), .dbg_req(dbg_req), .hwmg_req(hwmg_req), .ret_strobe(ret_strobe),
        .mode_o(mode_o), .cause_o(cause_o), .enter_o(enter_o), .saved_mode_o(saved_mode_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Cause of the winning request; r bits: 0 mem, 1 unk, 2 svc, 3 dbg, 4 hw.
    function automatic int exp_cause(input logic [4:0] r, input int mode);
        if (r[0]) return 1;
        if (r[1]) return 2;
        if (r[2]) return 3;
        if (r[3]) return (mode == 1) ? 5 : 4;
        if (r[4]) return 6;
        return 0;
    endfunction

    function automatic int exp_saved(input int mode);
        return (mode == 2) ? 1 : 0;
    endfunction

    task automatic check_all(input string tag, input int ecause, input bit eent);
        chk(tag, "mode", int'(mode_o), m_mode);
        chk(tag, "saved", int'(saved_mode_o), exp_saved(m_mode));
        chk(tag, "enter", int'(enter_o), int'(eent));
        chk(tag, "cause", int'(cause_o), ecause);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {hwmg_req, dbg_req, svc_req, unkins_req, memflt_req} = '0;
        ret_strobe = 1'b0;
        @(posedge clk); #1;
        m_mode = 0; m_term = 0;
        check_all("R1", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic [4:0] r, input logic rt);
        string tag;
        bit    tk, rtn;
        int    ec;
        @(negedge clk);
        {hwmg_req, dbg_req, svc_req, unkins_req, memflt_req} = r;
        ret_strobe = rt;
        tk  = (r != 0) && (m_mode != 2);
        rtn = rt && !tk && (m_mode == 1 || (m_mode == 2 && !m_term));
        ec  = tk ? exp_cause(r, m_mode) : 0;
        if (m_mode == 2 && m_term)              tag = "R5";
        else if (m_mode == 2 && r != 0)         tag = "R9";
        else if (tk && rt)                      tag = "R10";
        else if (tk && $countones(r) > 1)       tag = "R6";
        else if (tk && m_mode == 1 && r[3])     tag = "R4";
        else if (tk && m_mode == 0)             tag = "R2";
        else if (tk)                            tag = "R3";
        else if (rt)                            tag = "R7";
        else                                    tag = "R8";
        @(posedge clk); #1;
        if (tk) begin
            if (m_mode == 1 && ec != 5) m_term = 1;
            m_mode = m_mode + 1;
        end else if (rtn) begin
            m_mode = m_mode - 1;
        end
        check_all(tag, ec, tk);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        step(5'b00000, 1'b1);   // R7 return in user ignored
        step(5'b00100, 1'b0);   // R2 svc from user
        step(5'b00000, 1'b0);   // R8 pulse drops
        step(5'b01000, 1'b0);   // R4 debug in super -> cause 5
        step(5'b00100, 1'b0);   // R9 ignored in fault
        step(5'b00000, 1'b1);   // R4 back to supervisor
        step(5'b00000, 1'b1);   // R7 back to user
        step(5'b11111, 1'b0);   // R6 memfault wins
        step(5'b00000, 1'b1);
        step(5'b11110, 1'b0);   // R6 unknown wins
        step(5'b00000, 1'b1);
        step(5'b11100, 1'b0);   // R6 svc wins
        step(5'b00000, 1'b1);
        step(5'b11000, 1'b0);   // R6 debug wins in user -> cause 4
        step(5'b00000, 1'b1);
        step(5'b10000, 1'b1);   // R10 request beats return
        step(5'b00001, 1'b0);   // R5 memfault in super -> terminal
        step(5'b00000, 1'b1);   // R5 return ignored
        step(5'b01000, 1'b0);   // R5 request ignored
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] r;
            for (int b = 0; b < 5; b++) r[b] = ($urandom % 6) == 0;
            if (($urandom % 60) == 0) do_reset();
            else step(r, ($urandom % 4) == 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule